// File: doc/BRIEF.md
# Legal Transition Graph Pruning Engine

This block searches a directed graph of permitted transitions between the codes of one bus segment. It finds the widest data word that can be carried over that segment using only permitted transitions. The segment has `SEG_W` physical wires, so the graph has `2^SEG_W` vertices. The graph is held as an adjacency bit matrix in internal registers, and software or a build step loads it one row at a time through a write port.

After `start`, the engine tries a target width `m`, beginning at `SEG_W-1`. For each target it removes every vertex that has too few edges into the surviving set. It keeps making passes until a whole pass removes nothing. If enough vertices survive, it stops and reports `m` and the surviving vertex mask. Otherwise it lowers `m` and starts again from the full graph.

The controller has four named states:
- `ST_IDLE`: waits for `start`.
- `ST_SCAN`: evaluates one vertex per cycle.
- `ST_JUDGE`: runs at the end of a pass and picks one of four transitions:
  - another pass, when the pass removed something;
  - success, into `ST_DONE`;
  - lower width, back to `ST_SCAN` with a fresh set;
  - failure, into `ST_DONE`.
- `ST_DONE`: holds the result until the next `start`.

Top module: `ltg_prune_engine`

## Requirements
- R1: After reset, `busy`, `done` and `found` are 0.
- R2: When `wr_en` is high and `busy` is low, row `wr_addr` of the matrix takes `wr_row`. Bit j of row i means an edge from vertex i to vertex j, and bit i of row i is the self edge. A write while `busy` is high is ignored.
- R3: A `start` seen while `busy` is low makes `busy` high on the next cycle, with `width_m` equal to `SEG_W-1` and all vertices alive. A `start` while `busy` is high is ignored.
- R4: A vertex's out-degree counts its set row bits, including the self edge, whose destination is still alive. A live vertex whose out-degree is below `2^m` is removed.
- R5: Pruning passes repeat at the same `m` until a full pass over all vertices removes none.
- R6: If at least `2^m` vertices remain after convergence, the engine enters `ST_DONE` with `found=1`, `width_m=m` and `alive_mask` set to the survivors. Every survivor then has at least `2^m` edges into `alive_mask`.
- R7: If fewer than `2^m` vertices remain and `m>0`, `m` drops by one and pruning restarts with every vertex alive. The reported `m` is therefore the largest width that succeeds.
- R8: If `m=0` also fails, `done` rises with `found=0`, `width_m=0` and `alive_mask=0`.
- R9: `done` and the result stay unchanged until the next `start`. `busy` and `done` are never high together, and `m` never rises during a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Row write enable (honoured only when idle) |
| wr_addr | input | SEG_W | Row (source vertex) to write |
| wr_row | input | 2^SEG_W | Destination bits for that row |
| start | input | 1 | Begin a search |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid |
| found | output | 1 | An encodable width was found |
| width_m | output | clog2(SEG_W+1) | Encodable width result |
| alive_mask | output | 2^SEG_W | Surviving vertex set |

## Verification
The checker watches four things on every cycle:
- `busy` and `done` are never high together;
- `m` never rises during a search, which also catches a restart caused by a stray `start`;
- every success holds at least `2^m` survivors, and every failure reports zero width with an empty mask;
- the result stays stable while `done` is held.

Only the bench scenarios can show that the reported width is the largest one and that the mask is the exact greatest surviving set. They compare each outcome against a separately computed simultaneous-removal fixpoint. They cover many random graphs of varied density, a graph that needs a second pass, and a graph that reaches the failure corner. They also show that writes and starts issued mid-search leave the result unchanged.

// File: rtl/ltg_pkg.sv
package ltg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_JUDGE = 2'd2,
        ST_DONE  = 2'd3
    } ltg_state_e;
endpackage

// File: rtl/ltg_popcount.sv
module ltg_popcount #(
    parameter int W  = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/ltg_adj_store.sv
module ltg_adj_store #(
    parameter int NV = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [NV-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [NV-1:0] rdata
);
    logic [NV-1:0] rows [NV];

    for (genvar g = 0; g < NV; g++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rows[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                rows[g] <= wdata;
            end
        end
    end

    assign rdata = rows[raddr];
endmodule

// File: rtl/ltg_prune_engine.sv
module ltg_prune_engine #(
    parameter  int SEG_W = 3,
    localparam int NV    = 1 << SEG_W,
    localparam int MW    = $clog2(SEG_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_addr,
    input  logic [NV-1:0]    wr_row,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             found,
    output logic [MW-1:0]    width_m,
    output logic [NV-1:0]    alive_mask
);
    import ltg_pkg::*;

    localparam int AW = SEG_W;
    localparam int CW = $clog2(NV + 1);

    ltg_state_e    state_q, state_d;
    logic [AW-1:0] idx_q;
    logic [MW-1:0] m_q;
    logic [NV-1:0] alive_q;
    logic          changed_q;
    logic          found_q;

    logic [NV-1:0] row;
    logic [CW-1:0] deg;
    logic [CW-1:0] surv;
    logic [CW-1:0] thr;
    logic          drop;
    logic          last_idx;
    logic          idle_like;

    ltg_adj_store #(.NV(NV), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && !busy),
        .waddr (wr_addr),
        .wdata (wr_row),
        .raddr (idx_q),
        .rdata (row)
    );

    ltg_popcount #(.W(NV)) u_deg (
        .bits  (row & alive_q),
        .count (deg)
    );

    ltg_popcount #(.W(NV)) u_surv (
        .bits  (alive_q),
        .count (surv)
    );

    assign thr       = CW'(1) << m_q;
    assign drop      = alive_q[idx_q] && (deg < thr);
    assign last_idx  = (idx_q == AW'(NV - 1));
    assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) state_d = ST_SCAN;
            ST_SCAN:          if (last_idx) state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (changed_q)       state_d = ST_SCAN;
                else if (surv >= thr) state_d = ST_DONE;
                else if (m_q == '0)   state_d = ST_DONE;
                else                  state_d = ST_SCAN;
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            m_q       <= '0;
            alive_q   <= '0;
            changed_q <= 1'b0;
            found_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        idx_q     <= '0;
                        m_q       <= MW'(SEG_W - 1);
                        alive_q   <= '1;
                        changed_q <= 1'b0;
                        found_q   <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (drop) begin
                        alive_q[idx_q] <= 1'b0;
                        changed_q      <= 1'b1;
                    end
                    idx_q <= last_idx ? '0 : idx_q + AW'(1);
                end
                ST_JUDGE: begin
                    idx_q     <= '0;
                    changed_q <= 1'b0;
                    if (!changed_q) begin
                        if (surv >= thr) begin
                            found_q <= 1'b1;
                        end else if (m_q == '0) begin
                            found_q <= 1'b0;
                            alive_q <= '0;
                        end else begin
                            m_q     <= m_q - MW'(1);
                            alive_q <= '1;
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q == ST_SCAN) || (state_q == ST_JUDGE);
        done       = (state_q == ST_DONE);
        found      = found_q && (state_q == ST_DONE);
        width_m    = m_q;
        alive_mask = alive_q;
    end
endmodule

// File: rtl/ltg_prune_checker.sv
module ltg_prune_checker #(
    parameter  int SEG_W = 3,
    localparam int NV    = 1 << SEG_W,
    localparam int MW    = $clog2(SEG_W + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          found,
    input logic [MW-1:0] width_m,
    input logic [NV-1:0] alive_mask,
    input logic [MW-1:0] m_q
);
    // R9: never busy and done at once
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9: target width only falls during a search (a restart would raise it)
    p_m_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (m_q <= $past(m_q)));

    // R3: accepted start enters search at the top width
    p_start_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && width_m == MW'(SEG_W - 1)));

    // R6: success carries enough survivors
    p_enough_surv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> ($countones(alive_mask) >= (1 << width_m)));

    // R8: failure reports zero width and empty set
    p_fail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (width_m == '0 && alive_mask == '0));

    // R9: result held while no new start
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(alive_mask) && $stable(width_m) && $stable(found)));
endmodule

bind ltg_prune_engine ltg_prune_checker #(.SEG_W(SEG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .found      (found),
    .width_m    (width_m),
    .alive_mask (alive_mask),
    .m_q        (m_q)
);

// File: tb/ltg_prune_engine_bench.sv
module ltg_prune_engine_bench;
    localparam int SEG_W = 3;
    localparam int NV    = 1 << SEG_W;
    localparam int MW    = $clog2(SEG_W + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [SEG_W-1:0] wr_addr = '0;
    logic [NV-1:0]    wr_row = '0;
    logic             start = 1'b0;
    logic             busy, done, found;
    logic [MW-1:0]    width_m;
    logic [NV-1:0]    alive_mask;

    always #10 clk = ~clk;

    ltg_prune_engine #(.SEG_W(SEG_W)) u_ltg_prune_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_row(wr_row),
        .start(start), .busy(busy), .done(done), .found(found),
        .width_m(width_m), .alive_mask(alive_mask)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [NV-1:0] gmem [NV];
    int            ref_m;
    bit            ref_f;
    logic [NV-1:0] ref_mask;
    logic [31:0]   lfsr = 32'hACE1_2467;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // independent model: simultaneous removal to a fixpoint, widths tried top down
    task automatic compute_ref();
        logic [NV-1:0] al, nx;
        bit ch;
        ref_f = 0; ref_m = 0; ref_mask = '0;
        for (int m = SEG_W - 1; m >= 0; m--) begin
            al = '1;
            do begin
                nx = al;
                for (int v = 0; v < NV; v++)
                    if (al[v] && $countones(gmem[v] & al) < (1 << m)) nx[v] = 1'b0;
                ch = (nx != al);
                al = nx;
            end while (ch);
            if ($countones(al) >= (1 << m)) begin
                ref_f = 1; ref_m = m; ref_mask = al;
                return;
            end
        end
    endtask

    task automatic write_row(input int a, input logic [NV-1:0] r);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = SEG_W'(a); wr_row = r;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_graph();
        for (int i = 0; i < NV; i++) write_row(i, gmem[i]);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R3 busy after start", 32'(busy), 1);
        chk(width_m == MW'(SEG_W - 1), "R3 start width", 32'(width_m), SEG_W - 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 4000) begin @(negedge clk); n++; end
    endtask

    task automatic check_result(input string tag);
        compute_ref();
        chk(done == 1'b1, {tag, " R9 done"}, 32'(done), 1);
        chk(found == ref_f, {tag, " R6/R8 found"}, 32'(found), 32'(ref_f));
        chk(width_m == MW'(ref_m), {tag, " R7 width"}, 32'(width_m), 32'(ref_m));
        chk(alive_mask == ref_mask, {tag, " R4/R5 mask"}, 32'(alive_mask), 32'(ref_mask));
        if (found) begin
            for (int v = 0; v < NV; v++)
                if (alive_mask[v])
                    chk($countones(gmem[v] & alive_mask) >= (1 << width_m), {tag, " R6 closure"},
                        32'($countones(gmem[v] & alive_mask)), 32'(1 << width_m));
        end
    endtask

    task automatic run_graph(input string tag);
        load_graph();
        pulse_start();
        wait_done();
        check_result(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
        chk(done == 1'b0, "R1 done", 32'(done), 0);
        chk(found == 1'b0, "R1 found", 32'(found), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // complete graph: top width, all survive
        for (int i = 0; i < NV; i++) gmem[i] = '1;
        run_graph("full R6");
        chk(width_m == MW'(SEG_W - 1) && alive_mask == '1, "R6 full graph", 32'(alive_mask), 32'hFF);

        // R9: result held
        repeat (4) @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R9 hold done", 32'({busy, done}), 1);
        chk(alive_mask == '1, "R9 hold mask", 32'(alive_mask), 32'hFF);

        // R2: write during search ignored; R3: start during search ignored
        pulse_start();
        write_row(0, '0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        check_result("busy-write R2/R3");
        chk(alive_mask[0] == 1'b1, "R2 ignored write", 32'(alive_mask), 32'hFF);

        // R8: empty graph fails
        for (int i = 0; i < NV; i++) gmem[i] = '0;
        run_graph("empty R8");
        chk(found == 1'b0 && width_m == '0 && alive_mask == '0, "R8 failure", 32'(alive_mask), 0);

        // R7: self edges only -> width 0, all alive
        for (int i = 0; i < NV; i++) gmem[i] = NV'(1) << i;
        run_graph("self R7");
        chk(found == 1'b1 && width_m == '0 && alive_mask == '1, "R7 self loops", 32'(width_m), 0);

        // R5: removal of vertex 7 late in pass 1 forces vertex 0 out in pass 2
        gmem[0] = 8'h87;
        for (int i = 1; i < 7; i++) gmem[i] = 8'h7E;
        gmem[7] = 8'h80;
        run_graph("cascade R5");
        chk(alive_mask == 8'h7E && width_m == 2'd2, "R5 second pass", 32'(alive_mask), 32'h7E);

        // R4/R7: random graphs of varied density
        for (int t = 0; t < 60; t++) begin
            for (int i = 0; i < NV; i++) begin
                logic [NV-1:0] a = NV'(rnd());
                logic [NV-1:0] b = NV'(rnd());
                case (t % 4)
                    0: gmem[i] = a & b;
                    1: gmem[i] = a | b;
                    2: gmem[i] = a;
                    default: gmem[i] = a & b & NV'(rnd());
                endcase
            end
            run_graph("random R4");
        end

        report();
    end
endmodule